// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a three-wire serial stereo stream (bit clock, word-select and data) into parallel samples. Each channel is a two's-complement word sent MSB first. The word-select line marks which channel is active. A 2-bit format select chooses one of four framings: two framings anchored on the word-select edge, and two right-aligned framings whose words end at the next word-select edge. A 24-bit left sample and a 24-bit right sample come out together, with a one-cycle strobe, once per stereo frame.

The receiver runs in the system clock domain. It acts only in cycles where `sclk_en` is high. `sclk_en` is a single-cycle pulse that marks a rising bit-clock edge and is generated elsewhere. Both `lrck` and `sdata` are sampled in those cycles.

A channel word is closed when the word-select change is seen, so the format is decoded at the end of each half frame. The first pair after reset is released only after a complete left half and a complete right half have been received. In the right-aligned framings each half frame lasts 32 bit periods.

Top module: `pcm_serial_rx`

## Requirements
- R1: While reset is held and after it is released, `left_out` and `right_out` are zero and `frame_valid` is low until the first pair is released.
- R2: Format 2'b00: `lrck` low marks the left half. The MSB is the second enabled bit after the `lrck` change. The first bit of a half and any bit after the 24th word bit are ignored.
- R3: Format 2'b01: `lrck` high marks the left half. The MSB is the first enabled bit after the `lrck` change, and bits after the 24th are ignored.
- R4: Format 2'b10: `lrck` high marks the left half, each half is 32 bits long, and the word is the last 24 bits before the `lrck` change, with the LSB last.
- R5: Format 2'b11: same as R4, but the word is the last 16 bits. It is output left-aligned as {word, 8'h00}.
- R6: `frame_valid` pulses for exactly one cycle, the cycle after the enabled sample that sees `lrck` leave the right-channel level. Both outputs update together with it and hold their values at all other times.
- R7: `lrck` and `sdata` have no effect in cycles where `sclk_en` is low.
- R8: After reset, no pair is released until a left half and then a right half, each begun by an observed `lrck` change, have completed.
- R9: In formats 2'b00 and 2'b01, a half frame that carries fewer than 24 word bits yields a word zero-padded at the LSB end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_en | input | 1 | One-cycle pulse per rising bit-clock edge |
| lrck | input | 1 | Word-select (channel) line |
| sdata | input | 1 | Serial data, MSB first |
| fmt_sel | input | 2 | 00 I2S, 01 left-justified, 10 right-justified 24, 11 right-justified 16 |
| left_out | output | 24 | Left sample |
| right_out | output | 24 | Right sample |
| frame_valid | output | 1 | One-cycle strobe for a new sample pair |

## Verification
The assertions take for granted that `fmt_sel` is stable while a stream is running. They also assume `sclk_en` is a clean pulse, so that the level `lrck` shows at the strobe identifies the left half. The stimulus therefore resets the block before every format change and sets the format before the first enabled bit. It toggles `sdata` and `lrck` only in the cycles between enables, where they must be ignored. Positions that the chosen format ignores carry ones, so a misplaced bit window shows up in the captured words.

// File: rtl/pcm_rx_pkg.sv
// Shared types for the serial audio receiver.
package pcm_rx_pkg;
    // Framing selected by the 2-bit format input
    typedef enum logic [1:0] {
        FMT_I2S  = 2'b00,
        FMT_LJ   = 2'b01,
        FMT_RJ24 = 2'b10,
        FMT_RJ16 = 2'b11
    } fmt_e;
endpackage

// File: rtl/rx_edge_track.sv
// Tracks the word-select line on bit-clock enables.
// Reports the enabled cycle in which lrck changes, and the position of the
// current bit within its half frame (0 = first bit after the change).
// Assumes sclk_en is a single-cycle pulse per bit.
module rx_edge_track #(
    parameter int POS_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_en,
    input  logic             lrck,
    output logic             edge_o,
    output logic [POS_W-1:0] pos_o,
    output logic             prev_lrck_o,
    output logic             synced_o
);
    localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

    logic             lrck_q;
    logic             primed;
    logic [POS_W-1:0] cnt;
    logic             synced;

    // Change detect and saturating bit position
    always_comb begin
        edge_o = sclk_en && primed && (lrck != lrck_q);
        if (edge_o)
            pos_o = '0;
        else if (cnt == POS_MAX)
            pos_o = POS_MAX;
        else
            pos_o = cnt + 1'b1;
    end

    // Remember last sampled level, position and whether a half began cleanly
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lrck_q <= 1'b0;
            primed <= 1'b0;
            cnt    <= '0;
            synced <= 1'b0;
        end else if (sclk_en) begin
            lrck_q <= lrck;
            primed <= 1'b1;
            cnt    <= pos_o;
            if (edge_o)
                synced <= 1'b1;
        end
    end

    assign prev_lrck_o = lrck_q;
    assign synced_o    = synced;
endmodule

// File: rtl/rx_word_collect.sv
// Assembles one channel word per half frame.
// Edge-anchored formats fill a zero-cleared register by position. Right-aligned
// formats keep a shift register of the most recent bits. word_o is the word of
// the half frame that ends in the current edge cycle.
module rx_word_collect
    import pcm_rx_pkg::*;
#(
    parameter int WORD_W  = 24,
    parameter int SHORT_W = 16,
    parameter int POS_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_en,
    input  logic              edge_i,
    input  logic [POS_W-1:0]  pos_i,
    input  logic              sdata,
    input  fmt_e              fmt,
    output logic [WORD_W-1:0] word_o
);
    localparam int PAD_W = WORD_W - SHORT_W;

    logic [WORD_W-1:0] acc;
    logic [WORD_W-1:0] acc_nxt;
    logic [WORD_W-1:0] shreg;
    logic [POS_W:0]    idx;
    logic              i2s;
    logic              in_range;

    // Place the incoming bit by its position for the edge-anchored formats
    always_comb begin
        i2s      = (fmt == FMT_I2S);
        idx      = {1'b0, pos_i} - {{POS_W{1'b0}}, i2s};
        in_range = (pos_i >= {{(POS_W-1){1'b0}}, i2s}) &&
                   (idx < (POS_W+1)'(WORD_W));
        acc_nxt  = edge_i ? '0 : acc;
        for (int b = 0; b < WORD_W; b++) begin
            if (in_range && idx == (POS_W+1)'(WORD_W - 1 - b))
                acc_nxt[b] = sdata;
        end
    end

    // Update both collectors on each bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc   <= '0;
            shreg <= '0;
        end else if (sclk_en) begin
            acc   <= acc_nxt;
            shreg <= {shreg[WORD_W-2:0], sdata};
        end
    end

    // Select the finished word for the active format
    always_comb begin
        unique case (fmt)
            FMT_I2S, FMT_LJ: word_o = acc;
            FMT_RJ24:        word_o = shreg;
            default:         word_o = {shreg[SHORT_W-1:0], {PAD_W{1'b0}}};
        endcase
    end
endmodule

// File: rtl/rx_pair_out.sv
// Pairs finished channel words and releases them together.
// A left word is held until the following right word finishes; both then
// update the outputs with a one-cycle strobe. Assumes fmt is stable.
module rx_pair_out
    import pcm_rx_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              edge_i,
    input  logic              synced_i,
    input  logic              prev_lrck_i,
    input  fmt_e              fmt,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] left_o,
    output logic [WORD_W-1:0] right_o,
    output logic              valid_o
);
    logic [WORD_W-1:0] left_hold;
    logic              have_left;
    logic              was_left;

    // Channel of the half frame that is ending
    assign was_left = (fmt == FMT_I2S) ? !prev_lrck_i : prev_lrck_i;

    // Hold left word, release pair on a completed right word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_hold <= '0;
            have_left <= 1'b0;
            left_o    <= '0;
            right_o   <= '0;
            valid_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (edge_i && synced_i) begin
                if (was_left) begin
                    left_hold <= word_i;
                    have_left <= 1'b1;
                end else if (have_left) begin
                    left_o    <= left_hold;
                    right_o   <= word_i;
                    valid_o   <= 1'b1;
                    have_left <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/pcm_serial_rx_chk.sv
// Property checker for pcm_serial_rx, attached by bind below.
// Assumes fmt_sel is stable while a stream runs.
module pcm_serial_rx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sclk_en,
    input logic        lrck,
    input logic [1:0]  fmt_sel,
    input logic [23:0] left_out,
    input logic [23:0] right_out,
    input logic        frame_valid
);
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid); // R6

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |-> ($stable(left_out) && $stable(right_out))); // R6

    AST_VALID_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> $past(sclk_en)); // R7

    AST_LEFT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> ($past(lrck) == (fmt_sel != 2'b00))); // R2

    AST_SHORT_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && fmt_sel == 2'b11) |->
            (left_out[7:0] == 8'h00 && right_out[7:0] == 8'h00)); // R5
endmodule

bind pcm_serial_rx pcm_serial_rx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk_en     (sclk_en),
    .lrck        (lrck),
    .fmt_sel     (fmt_sel),
    .left_out    (left_out),
    .right_out   (right_out),
    .frame_valid (frame_valid)
);

// File: rtl/pcm_serial_rx.sv
// Multi-format serial audio receiver top.
// Samples lrck/sdata on sclk_en pulses, decodes one of four framings and
// releases a stereo pair once per frame. Assumes fmt_sel is static per stream.
module pcm_serial_rx
    import pcm_rx_pkg::*;
#(
    parameter int WORD_W  = 24,
    parameter int SHORT_W = 16,
    parameter int POS_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_en,
    input  logic              lrck,
    input  logic              sdata,
    input  logic [1:0]        fmt_sel,
    output logic [WORD_W-1:0] left_out,
    output logic [WORD_W-1:0] right_out,
    output logic              frame_valid
);
    fmt_e              fmt;
    logic              edge_w;
    logic [POS_W-1:0]  pos_w;
    logic              prev_lrck_w;
    logic              synced_w;
    logic [WORD_W-1:0] word_w;

    assign fmt = fmt_e'(fmt_sel);

    rx_edge_track #(.POS_W(POS_W)) u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_en     (sclk_en),
        .lrck        (lrck),
        .edge_o      (edge_w),
        .pos_o       (pos_w),
        .prev_lrck_o (prev_lrck_w),
        .synced_o    (synced_w)
    );

    rx_word_collect #(.WORD_W(WORD_W), .SHORT_W(SHORT_W), .POS_W(POS_W)) u_word (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_en (sclk_en),
        .edge_i  (edge_w),
        .pos_i   (pos_w),
        .sdata   (sdata),
        .fmt     (fmt),
        .word_o  (word_w)
    );

    rx_pair_out #(.WORD_W(WORD_W)) u_pair (
        .clk         (clk),
        .rst_n       (rst_n),
        .edge_i      (edge_w),
        .synced_i    (synced_w),
        .prev_lrck_i (prev_lrck_w),
        .fmt         (fmt),
        .word_i      (word_w),
        .left_o      (left_out),
        .right_o     (right_out),
        .valid_o     (frame_valid)
    );
endmodule

// File: tb/pcm_serial_rx_bench.sv
module pcm_serial_rx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_en = 1'b0;
    logic        lrck = 1'b0;
    logic        sdata = 1'b0;
    logic [1:0]  fmt_sel = 2'b00;
    logic [23:0] left_out, right_out;
    logic        frame_valid;

    int checks = 0;
    int errors = 0;
    int vcount = 0;
    logic [23:0] first_l, first_r, last_l, last_r;

    always #5 clk = ~clk;

    pcm_serial_rx u_pcm_serial_rx (
        .clk(clk), .rst_n(rst_n), .sclk_en(sclk_en), .lrck(lrck),
        .sdata(sdata), .fmt_sel(fmt_sel), .left_out(left_out),
        .right_out(right_out), .frame_valid(frame_valid)
    );

    // vectors: {fmt, left, right}
    localparam logic [49:0] VEC [8] = '{
        {2'b00, 24'h123456, 24'hABCDEF},
        {2'b00, 24'h800000, 24'h7FFFFF},
        {2'b01, 24'hA5A5A5, 24'h5A5A5A},
        {2'b01, 24'h000001, 24'hFFFFFE},
        {2'b10, 24'hC0FFEE, 24'h012345},
        {2'b10, 24'h800001, 24'hFFFFFE},
        {2'b11, 24'h00BEEF, 24'h007FFF},
        {2'b11, 24'h008000, 24'h00FFFF}
    };

    // record released pairs
    always @(posedge clk) begin
        #1;
        if (frame_valid) begin
            if (vcount == 0) begin
                first_l = left_out;
                first_r = right_out;
            end
            last_l = left_out;
            last_r = right_out;
            vcount++;
        end
    end

    task automatic chk(input bit ok, input string req,
                       input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // one enabled bit, then one gap cycle with garbage on the lines
    task automatic send_bit(input logic lv, input logic dv);
        @(negedge clk);
        lrck = lv; sdata = dv; sclk_en = 1'b1;
        @(negedge clk);
        sclk_en = 1'b0; sdata = ~dv; lrck = ~lv;
    endtask

    function automatic logic hbit(input logic [1:0] f, input logic [23:0] w,
                                  input int p, input int hl);
        int e;
        e = hl - 1 - p;
        case (f)
            2'b00:   return (p >= 1 && p <= 24) ? w[24-p] : 1'b1;
            2'b01:   return (p < 24) ? w[23-p] : 1'b1;
            2'b10:   return (e < 24) ? w[e] : 1'b1;
            default: return (e < 16) ? w[e] : 1'b1;
        endcase
    endfunction

    function automatic logic [23:0] top_mask(input int n);
        logic [23:0] m;
        for (int b = 0; b < 24; b++) m[23-b] = (b < n);
        return m;
    endfunction

    task automatic send_frame(input logic [1:0] f, input logic [23:0] l,
                              input logic [23:0] r, input int hl);
        logic fh;
        fh = (f != 2'b00);
        for (int p = 0; p < hl; p++) send_bit(fh, hbit(f, l, p, hl));
        for (int p = 0; p < hl; p++) send_bit(~fh, hbit(f, r, p, hl));
    endtask

    task automatic do_reset(input logic [1:0] f);
        @(negedge clk);
        rst_n = 1'b0; sclk_en = 1'b0; fmt_sel = f;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        vcount = 0;
    endtask

    // lead-in at the right-channel level so the frame starts on an edge
    task automatic lead_in(input logic [1:0] f);
        logic fh;
        fh = (f != 2'b00);
        send_bit(~fh, 1'b0);
        send_bit(~fh, 1'b0);
    endtask

    task automatic close_frame(input logic [1:0] f);
        send_bit(f != 2'b00, 1'b0);
        repeat (3) @(negedge clk);
    endtask

    function automatic string fmt_req(input logic [1:0] f);
        case (f)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %h expected %h", 24'h0, 24'h1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [1:0]  f;
        logic [23:0] l, r, el, er;

        // R1 reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(left_out == 0 && right_out == 0 && !frame_valid, "R1 in reset",
            left_out | right_out, 24'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(left_out == 0 && right_out == 0 && vcount == 0, "R1 after reset",
            left_out | right_out, 24'h0);

        // table walk over all formats
        for (int i = 0; i < 8; i++) begin
            {f, l, r} = VEC[i];
            el = (f == 2'b11) ? {l[15:0], 8'h00} : l;
            er = (f == 2'b11) ? {r[15:0], 8'h00} : r;
            do_reset(f);
            lead_in(f);
            send_frame(f, l, r, 32);
            close_frame(f);
            chk(vcount == 1, "R6 one pair per frame", 24'(vcount), 24'd1);
            chk(last_l == el, {fmt_req(f), " left"}, last_l, el);
            chk(last_r == er, {fmt_req(f), " right"}, last_r, er);
        end

        // R8: stream starting at a right half releases nothing
        do_reset(2'b01);
        send_bit(1'b1, 1'b0);
        send_bit(1'b1, 1'b0);
        for (int p = 0; p < 32; p++) send_bit(1'b0, 1'b1);
        close_frame(2'b01);
        chk(vcount == 0, "R8 right half without left", 24'(vcount), 24'd0);

        // R7: lrck toggling with sclk_en low does not close a word
        do_reset(2'b01);
        lead_in(2'b01);
        send_frame(2'b01, 24'h13579B, 24'h2468AC, 32);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            lrck = ~lrck; sdata = ~sdata;
        end
        chk(vcount == 0, "R7 no edge without enable", 24'(vcount), 24'd0);
        close_frame(2'b01);
        chk(vcount == 1 && last_l == 24'h13579B && last_r == 24'h2468AC,
            "R7 pair after enabled edge", last_r, 24'h2468AC);

        // R9: short halves are zero padded
        do_reset(2'b01);
        lead_in(2'b01);
        send_frame(2'b01, 24'hFEDCBA, 24'h987654, 16);
        close_frame(2'b01);
        el = 24'hFEDCBA & top_mask(16);
        er = 24'h987654 & top_mask(16);
        chk(last_l == el && last_r == er, "R9 left-justified 16-bit halves",
            last_l, el);

        do_reset(2'b00);
        lead_in(2'b00);
        send_frame(2'b00, 24'hFFFFFF, 24'h7FFFFF, 20);
        close_frame(2'b00);
        el = 24'hFFFFFF & top_mask(19);
        er = 24'h7FFFFF & top_mask(19);
        chk(last_l == el && last_r == er, "R9 I2S 20-bit halves", last_r, er);

        // R6: back-to-back frames, outputs hold after the strobe
        do_reset(2'b00);
        lead_in(2'b00);
        send_frame(2'b00, 24'h111111, 24'h222222, 32);
        send_frame(2'b00, 24'h333333, 24'h444444, 32);
        close_frame(2'b00);
        chk(vcount == 2, "R6 two frames two pairs", 24'(vcount), 24'd2);
        chk(first_l == 24'h111111 && first_r == 24'h222222, "R6 first pair",
            first_r, 24'h222222);
        chk(last_l == 24'h333333 && last_r == 24'h444444, "R6 second pair",
            last_r, 24'h444444);
        repeat (10) @(negedge clk);
        chk(left_out == 24'h333333 && right_out == 24'h444444 && !frame_valid,
            "R6 outputs hold", right_out, 24'h444444);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule